// File: doc/BRIEF.md
# Virtual PHY Management Register Slave

This block sits on a shared Ethernet management bus (MDC clock, MDIO data) and answers as if it were one more PHY at a fixed non-zero station address. A real PHY can share the same two wires at address 0. The block gives a host MAC access to a small controller register space. Identifier words describe the controller. Three read-only words return a 48-bit MAC address that another block supplies. A status word mirrors a parallel input vector. Read/write control words and a watchdog time field drive parallel outputs into the rest of the controller.

MDC and MDIO are sampled in the system clock domain through a synchronizer, and the system clock must run at least four times faster than MDC. Frame decoding runs only on detected MDC rising edges. The data driven back toward the host also changes only on those edges, so the host can sample each bit on the following rising edge. The MDIO output is meant for a tri-state pad: the pad drives only while the output enable is high.

Top module: `vphy_mgmt_slave`

## Requirements
- R1: The slave responds only to station address 0x1A (parameter). A frame carrying any other address, including 0x00, never asserts `mdio_oe`, and a write frame to another address changes no register.
- R2: Register 2 reads OUI bits 21:6 and register 3 reads {OUI bits 5:0, 6-bit model, 4-bit revision}. With OUI 0x007201, model 0x01 and revision 0x0, these read 0x01C8 and 0x0410.
- R3: Register 4 is a 16-bit read/write identity word that resets to 0x0000 and appears on `ident3_o`.
- R4: Registers 5, 6 and 7 are 16-bit read/write control words on `ctl1_o`, `ctl2_o` and `ctl3_o`. They reset to 0x0000, 0x0000 and 0x00F0.
- R5: Register 8 returns `status_in` as it stands in the cycle where the read header's last bit is taken.
- R6: Registers 9, 10 and 11 return `mac_addr[47:32]`, `[31:16]` and `[15:0]`. The first address byte (`mac_addr[47:40]`) is therefore in bits 15:8 of register 9.
- R7: In register 12, bits 7:0 are the writable watchdog time, shown on `wdt_time_o`. Bits 15:8 always read 0, and the register resets to 0x0000.
- R8: Reads of registers 0, 1, 13, 14, 15 and 16 to 31 return 0x0000. Writes to registers 0 to 3, 8 to 11, 13 to 31 have no effect on any register.
- R9: A frame is accepted only after at least 32 consecutive ones followed by start bits 0,1. Opcode 10 is a read and 01 is a write. A frame with 31 or fewer preamble ones, or with opcode 00 or 11, has no effect and never drives MDIO.
- R10: In a read, MDIO is released during the first turnaround bit, driven 0 in the second, then driven with data bits 15 down to 0. It is released in the bit after bit 0. Both outputs change only in the clock cycle after a detected MDC rising edge.
- R11: A write changes its register only after the 16th data bit is sampled. Before that the output keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x MDC |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock from host |
| mdio_i | input | 1 | Management data as seen on the pad |
| mdio_o | output | 1 | Management data to drive |
| mdio_oe | output | 1 | Drive enable for the MDIO pad |
| status_in | input | 16 | Status vector returned by register 8 |
| mac_addr | input | 48 | MAC address, first byte in bits 47:40 |
| ident3_o | output | 16 | Register 4 contents |
| ctl1_o | output | 16 | Register 5 contents |
| ctl2_o | output | 16 | Register 6 contents |
| ctl3_o | output | 16 | Register 7 contents |
| wdt_time_o | output | 8 | Register 12 bits 7:0 |

## Verification
The hardest cases to reach from the ports are frames that almost qualify. One has exactly 31 preamble ones, another has an illegal opcode, and a third carries a neighbouring station address. Each must leave the decoder in a state where the next valid frame is still recognised. The bench drives these bit by bit. It always follows them with a valid frame, so a decoder that fell out of step shows up as a wrong readback. The turnaround timing is observed one MDC bit at a time by sampling the drive enable just before each rising edge. A sweep then writes a distinct pattern to all 32 addresses and reads every one back.

// File: rtl/vphy_pkg.sv
package vphy_pkg;
   localparam int PA_W  = 5;
   localparam int RA_W  = 5;
   localparam int REG_W = 16;
   localparam int NREG  = 16;

   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_WRITE = 2'b01;

   localparam int RA_ID1     = 2;
   localparam int RA_ID2     = 3;
   localparam int RA_ID3     = 4;
   localparam int RA_CTL1    = 5;
   localparam int RA_CTL2    = 6;
   localparam int RA_CTL3    = 7;
   localparam int RA_STAT    = 8;
   localparam int RA_MAC_HI  = 9;
   localparam int RA_MAC_MID = 10;
   localparam int RA_MAC_LO  = 11;
   localparam int RA_WDT     = 12;

   typedef enum logic [2:0] {
      FS_PRE, FS_START, FS_HDR, FS_RD_TA, FS_RD_DATA, FS_WR_TA, FS_WR_DATA, FS_SKIP
   } frm_st_t;
endpackage

// File: rtl/vphy_edge_sync.sv
module vphy_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc,
   input  logic mdio_i,
   output logic rise,
   output logic bit_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("vphy_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] mdc_s;
   logic [STAGES-1:0] io_s;
   logic              mdc_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_s <= '1;
         io_s  <= '1;
         mdc_d <= 1'b1;
      end else begin
         mdc_s <= {mdc_s[STAGES-2:0], mdc};
         io_s  <= {io_s[STAGES-2:0], mdio_i};
         mdc_d <= mdc_s[STAGES-1];
      end
   end

   assign rise  = mdc_s[STAGES-1] & ~mdc_d;
   assign bit_o = io_s[STAGES-1];

   // R10: edge pulses are one cycle wide
   a_r10_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/vphy_frame_fsm.sv
module vphy_frame_fsm
   import vphy_pkg::*;
#(
   parameter logic [PA_W-1:0] PHY_ADDR = 5'h1A,
   parameter int              PRE_LEN  = 32,
   parameter int              DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              bit_i,
   output logic [RA_W-1:0]   rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [RA_W-1:0]   wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              mdio_o,
   output logic              mdio_oe
);
   localparam int HDR_W     = 2 + PA_W + RA_W;
   localparam int CNT_W     = $clog2(DATA_W + 3) + 1;
   localparam int PRE_W     = $clog2(PRE_LEN + 1);
   localparam int SKIP_BITS = 2 + DATA_W;

   if (PRE_LEN < 1) begin : g_bad_pre
      $error("vphy_frame_fsm: PRE_LEN must be positive");
   end

   frm_st_t             st;
   logic [PRE_W-1:0]    pre_cnt;
   logic [CNT_W-1:0]    cnt;
   logic [HDR_W-1:0]    hdr;
   logic [DATA_W-1:0]   sh;
   logic [RA_W-1:0]     addr_q;

   logic [HDR_W-1:0]    hdr_nxt;
   logic [1:0]          op_w;
   logic [PA_W-1:0]     phy_w;
   logic                addr_hit;
   logic [DATA_W-1:0]   sh_nxt;

   assign hdr_nxt  = {hdr[HDR_W-2:0], bit_i};
   assign op_w     = hdr_nxt[HDR_W-1 -: 2];
   assign phy_w    = hdr_nxt[RA_W +: PA_W];
   assign addr_hit = (phy_w == PHY_ADDR);
   assign sh_nxt   = {sh[DATA_W-2:0], bit_i};
   assign rd_addr  = hdr_nxt[RA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FS_PRE;
         pre_cnt <= '0;
         cnt     <= '0;
         hdr     <= '0;
         sh      <= '0;
         addr_q  <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (rise) begin
            case (st)
               FS_PRE: begin
                  if (bit_i) begin
                     if (pre_cnt != PRE_W'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
                  end else if (pre_cnt == PRE_W'(PRE_LEN)) begin
                     st      <= FS_START;
                     pre_cnt <= '0;
                  end else begin
                     pre_cnt <= '0;
                  end
               end
               FS_START: begin
                  if (bit_i) begin
                     st  <= FS_HDR;
                     cnt <= CNT_W'(HDR_W - 1);
                  end else begin
                     st <= FS_PRE;
                  end
               end
               FS_HDR: begin
                  hdr <= hdr_nxt;
                  if (cnt == '0) begin
                     addr_q <= hdr_nxt[RA_W-1:0];
                     if (addr_hit && op_w == OP_READ) begin
                        sh <= rd_data;
                        st <= FS_RD_TA;
                     end else if (addr_hit && op_w == OP_WRITE) begin
                        st  <= FS_WR_TA;
                        cnt <= CNT_W'(1);
                     end else begin
                        st  <= FS_SKIP;
                        cnt <= CNT_W'(SKIP_BITS - 1);
                     end
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               FS_RD_TA: begin
                  mdio_oe <= 1'b1;
                  mdio_o  <= 1'b0;
                  st      <= FS_RD_DATA;
                  cnt     <= CNT_W'(DATA_W);
               end
               FS_RD_DATA: begin
                  if (cnt == '0) begin
                     mdio_oe <= 1'b0;
                     mdio_o  <= 1'b0;
                     st      <= FS_PRE;
                     pre_cnt <= '0;
                  end else begin
                     mdio_o <= sh[DATA_W-1];
                     sh     <= {sh[DATA_W-2:0], 1'b0};
                     cnt    <= cnt - 1'b1;
                  end
               end
               FS_WR_TA: begin
                  if (cnt == '0) begin
                     st  <= FS_WR_DATA;
                     cnt <= CNT_W'(DATA_W - 1);
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               FS_WR_DATA: begin
                  sh <= sh_nxt;
                  if (cnt == '0) begin
                     wr_en   <= 1'b1;
                     wr_addr <= addr_q;
                     wr_data <= sh_nxt;
                     st      <= FS_PRE;
                     pre_cnt <= '0;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               FS_SKIP: begin
                  if (cnt == '0) begin
                     st      <= FS_PRE;
                     pre_cnt <= '0;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               default: st <= FS_PRE;
            endcase
         end
      end
   end

   // R10: the first driven bit is the turnaround zero
   a_r10_ta_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_o);
   // R10: pad outputs move only after a detected MDC rise
   a_r10_edge_paced: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> ($stable(mdio_o) && $stable(mdio_oe)));
   // R1: frames being skipped never drive the pad
   a_r1_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FS_SKIP) |-> !mdio_oe);
   // R9: no write strobe is ever issued without a data-phase edge
   a_r9_wr_from_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_en) |-> $past(rise));
endmodule

// File: rtl/vphy_regbank.sv
module vphy_regbank
   import vphy_pkg::*;
#(
   parameter logic [23:0]      OUI      = 24'h007201,
   parameter logic [5:0]       MODEL    = 6'h01,
   parameter logic [3:0]       REV      = 4'h0,
   parameter logic [REG_W-1:0] CTL3_RST = 16'h00F0,
   parameter logic [REG_W-1:0] ID3_RST  = 16'h0000,
   parameter int               WDT_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [RA_W-1:0]   wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [RA_W-1:0]   rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic [REG_W-1:0]  status_in,
   input  logic [47:0]       mac_addr,
   output logic [REG_W-1:0]  ident3_o,
   output logic [REG_W-1:0]  ctl1_o,
   output logic [REG_W-1:0]  ctl2_o,
   output logic [REG_W-1:0]  ctl3_o,
   output logic [WDT_W-1:0]  wdt_time_o
);
   if (WDT_W < 1 || WDT_W > REG_W) begin : g_bad_wdt
      $error("vphy_regbank: WDT_W out of range");
   end

   localparam logic [REG_W-1:0] ID1_WORD = OUI[21:6];
   localparam logic [REG_W-1:0] ID2_WORD = {OUI[5:0], MODEL, REV};
   localparam logic [NREG-1:0]  WR_MASK  = (NREG'(1) << RA_ID3)  | (NREG'(1) << RA_CTL1) |
                                           (NREG'(1) << RA_CTL2) | (NREG'(1) << RA_CTL3) |
                                           (NREG'(1) << RA_WDT);

   logic [REG_W-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (WR_MASK[g]) begin : g_rw
         localparam logic [REG_W-1:0] RSTV = (g == RA_CTL3) ? CTL3_RST :
                                             (g == RA_ID3)  ? ID3_RST  : '0;
         localparam logic [REG_W-1:0] KEEP = (g == RA_WDT) ? REG_W'((1 << WDT_W) - 1) : '1;
         logic [REG_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 q <= RSTV;
            else if (wr_en && wr_addr == RA_W'(g))      q <= wr_data & KEEP;
         end
         assign regs[g] = q;
      end else begin : g_ro
         assign regs[g] = '0;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr[RA_W-1] == 1'b0) begin
         case (rd_addr[3:0])
            4'(RA_ID1):     rd_data = ID1_WORD;
            4'(RA_ID2):     rd_data = ID2_WORD;
            4'(RA_STAT):    rd_data = status_in;
            4'(RA_MAC_HI):  rd_data = mac_addr[47:32];
            4'(RA_MAC_MID): rd_data = mac_addr[31:16];
            4'(RA_MAC_LO):  rd_data = mac_addr[15:0];
            default:        rd_data = regs[rd_addr[3:0]];
         endcase
      end
   end

   assign ident3_o   = regs[RA_ID3];
   assign ctl1_o     = regs[RA_CTL1];
   assign ctl2_o     = regs[RA_CTL2];
   assign ctl3_o     = regs[RA_CTL3];
   assign wdt_time_o = regs[RA_WDT][WDT_W-1:0];

   // R8: a write aimed elsewhere leaves the first control word alone
   a_r8_ctl1_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != RA_W'(RA_CTL1)) |=> $stable(ctl1_o));
   // R4: a write to the first control word lands in the next cycle
   a_r4_ctl1_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RA_W'(RA_CTL1)) |=> (ctl1_o == $past(wr_data)));
   // R11: control words only move on a write strobe
   a_r11_ctl2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctl2_o));
endmodule

// File: rtl/vphy_mgmt_slave.sv
module vphy_mgmt_slave
   import vphy_pkg::*;
#(
   parameter logic [PA_W-1:0]  PHY_ADDR     = 5'h1A,
   parameter int               PREAMBLE_LEN = 32,
   parameter int               SYNC_STAGES  = 2,
   parameter logic [23:0]      OUI          = 24'h007201,
   parameter logic [5:0]       MODEL_NUM    = 6'h01,
   parameter logic [3:0]       REV_NUM      = 4'h0,
   parameter logic [REG_W-1:0] CTL3_RST     = 16'h00F0,
   parameter logic [REG_W-1:0] ID3_RST      = 16'h0000,
   parameter int               WDT_W        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdc,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic [REG_W-1:0]  status_in,
   input  logic [47:0]       mac_addr,
   output logic [REG_W-1:0]  ident3_o,
   output logic [REG_W-1:0]  ctl1_o,
   output logic [REG_W-1:0]  ctl2_o,
   output logic [REG_W-1:0]  ctl3_o,
   output logic [WDT_W-1:0]  wdt_time_o
);
   logic             rise;
   logic             sbit;
   logic [RA_W-1:0]  rd_addr;
   logic [REG_W-1:0] rd_data;
   logic             wr_en;
   logic [RA_W-1:0]  wr_addr;
   logic [REG_W-1:0] wr_data;

   vphy_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
      .rise(rise), .bit_o(sbit)
   );

   vphy_frame_fsm #(.PHY_ADDR(PHY_ADDR), .PRE_LEN(PREAMBLE_LEN), .DATA_W(REG_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .rise(rise), .bit_i(sbit),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   vphy_regbank #(.OUI(OUI), .MODEL(MODEL_NUM), .REV(REV_NUM),
                  .CTL3_RST(CTL3_RST), .ID3_RST(ID3_RST), .WDT_W(WDT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .status_in(status_in), .mac_addr(mac_addr),
      .ident3_o(ident3_o), .ctl1_o(ctl1_o), .ctl2_o(ctl2_o), .ctl3_o(ctl3_o),
      .wdt_time_o(wdt_time_o)
   );
endmodule

// File: tb/vphy_mgmt_slave_tb.sv
module vphy_mgmt_slave_tb;
   localparam int CLK_P = 10;
   localparam int HALF  = 5;
   localparam logic [23:0] OUI_V = 24'h007201;
   localparam logic [18:0] TR_HIT = {1'b0, 1'b1, 16'hFFFF, 1'b0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mdc = 1'b0;
   logic        mdio_i = 1'b1;
   logic [15:0] status_in = 16'h0000;
   logic [47:0] mac_addr = 48'h02_12_34_56_78_9A;
   logic        mdio_o, mdio_oe;
   logic [15:0] ident3_o, ctl1_o, ctl2_o, ctl3_o;
   logic [7:0]  wdt_time_o;

   vphy_mgmt_slave u_dut (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .status_in(status_in), .mac_addr(mac_addr),
      .ident3_o(ident3_o), .ctl1_o(ctl1_o), .ctl2_o(ctl2_o), .ctl3_o(ctl3_o),
      .wdt_time_o(wdt_time_o)
   );

   always #(CLK_P/2) clk = ~clk;

   int   n_chk = 0;
   int   n_bad = 0;
   logic saw_oe;
   logic [15:0] s_id3, s_c1, s_c2, s_c3;
   logic [7:0]  s_wdt;

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bit_cyc(input logic b, output logic so, output logic soe);
      @(negedge clk); mdc = 1'b0; mdio_i = b;
      repeat (HALF-1) @(negedge clk);
      so = mdio_o; soe = mdio_oe;
      @(negedge clk); mdc = 1'b1;
      repeat (HALF-1) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      logic so, soe;
      bit_cyc(b, so, soe);
      if (soe) saw_oe = 1'b1;
   endtask

   task automatic send_hdr(input int pre, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
      for (int i = 0; i < pre; i++) send_bit(1'b1);
      send_bit(1'b0); send_bit(1'b1);
      for (int i = 1; i >= 0; i--) send_bit(op[i]);
      for (int i = 4; i >= 0; i--) send_bit(phy[i]);
      for (int i = 4; i >= 0; i--) send_bit(ra[i]);
   endtask

   task automatic do_write(input int pre, input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] d);
      saw_oe = 1'b0;
      send_hdr(pre, op, phy, ra);
      send_bit(1'b1); send_bit(1'b0);
      for (int i = 15; i >= 0; i--) send_bit(d[i]);
      repeat (2*HALF) @(negedge clk);
   endtask

   task automatic do_read(input logic [4:0] phy, input logic [4:0] ra,
                          output logic [15:0] val, output logic [18:0] tr, output logic ta2_o);
      logic so, soe;
      saw_oe = 1'b0;
      send_hdr(32, 2'b10, phy, ra);
      val = '0; tr = '0; ta2_o = 1'b1;
      for (int i = 18; i >= 0; i--) begin
         bit_cyc(1'b1, so, soe);
         tr[i] = soe;
         if (i == 17) ta2_o = so;
         if (i >= 1 && i <= 16) val[i-1] = so;
      end
   endtask

   function automatic logic [15:0] exp_rd(input logic [4:0] ra);
      if (ra[4]) return 16'h0000;
      case (ra[3:0])
         4'd2:  return OUI_V[21:6];
         4'd3:  return {OUI_V[5:0], 6'h01, 4'h0};
         4'd4:  return s_id3;
         4'd5:  return s_c1;
         4'd6:  return s_c2;
         4'd7:  return s_c3;
         4'd8:  return status_in;
         4'd9:  return mac_addr[47:32];
         4'd10: return mac_addr[31:16];
         4'd11: return mac_addr[15:0];
         4'd12: return {8'h00, s_wdt};
         default: return 16'h0000;
      endcase
   endfunction

   function automatic string req_of(input logic [4:0] ra);
      if (ra[4]) return "R8";
      case (ra[3:0])
         4'd2, 4'd3: return "R2";
         4'd4: return "R3";
         4'd5, 4'd6, 4'd7: return "R4";
         4'd8: return "R5";
         4'd9, 4'd10, 4'd11: return "R6";
         4'd12: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic read_chk(input logic [4:0] ra, input string req);
      logic [15:0] v; logic [18:0] tr; logic t2;
      do_read(5'h1A, ra, v, tr, t2);
      chk(v, exp_rd(ra), req, $sformatf("read reg %0d", ra));
      chk(tr, TR_HIT, "R10", $sformatf("drive trace reg %0d", ra));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] v; logic [18:0] tr; logic t2;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // reset state (R3, R4, R7)
      chk(ctl1_o, 16'h0000, "R4", "ctl1 reset");
      chk(ctl2_o, 16'h0000, "R4", "ctl2 reset");
      chk(ctl3_o, 16'h00F0, "R4", "ctl3 reset");
      chk(ident3_o, 16'h0000, "R3", "ident3 reset");
      chk(wdt_time_o, 8'h00, "R7", "wdt reset");
      chk(mdio_oe, 1'b0, "R10", "idle drive enable");
      s_id3 = 16'h0000; s_c1 = 16'h0000; s_c2 = 16'h0000; s_c3 = 16'h00F0; s_wdt = 8'h00;

      // R2 identifiers and R10 turnaround shape
      do_read(5'h1A, 5'd2, v, tr, t2);
      chk(v, 16'h01C8, "R2", "id word 1");
      chk(tr, TR_HIT, "R10", "turnaround/release trace");
      chk(t2, 1'b0, "R10", "second turnaround bit value");
      chk(saw_oe, 1'b0, "R10", "no drive during header");
      read_chk(5'd3, "R2");

      // R6 MAC words
      read_chk(5'd9, "R6");
      read_chk(5'd10, "R6");
      read_chk(5'd11, "R6");
      do_read(5'h1A, 5'd9, v, tr, t2);
      chk(v[15:8], 8'h02, "R6", "first MAC byte in reg 9 high");

      // R5 status patterns
      status_in = 16'hA5C3; read_chk(5'd8, "R5");
      status_in = 16'h8000; read_chk(5'd8, "R5");
      status_in = 16'h5000; read_chk(5'd8, "R5");

      // R3, R4, R7 writes
      do_write(32, 2'b01, 5'h1A, 5'd4, 16'hBEEF); s_id3 = 16'hBEEF;
      chk(ident3_o, 16'hBEEF, "R3", "ident3 after write");
      do_write(32, 2'b01, 5'h1A, 5'd5, 16'h1234); s_c1 = 16'h1234;
      chk(ctl1_o, 16'h1234, "R4", "ctl1 after write");
      do_write(32, 2'b01, 5'h1A, 5'd7, 16'hE500); s_c3 = 16'hE500;
      chk(ctl3_o, 16'hE500, "R4", "ctl3 after write");
      do_write(32, 2'b01, 5'h1A, 5'd12, 16'hABCD); s_wdt = 8'hCD;
      chk(wdt_time_o, 8'hCD, "R7", "wdt time after write");
      read_chk(5'd12, "R7");

      // R11 write lands only after the last data bit
      saw_oe = 1'b0;
      send_hdr(32, 2'b01, 5'h1A, 5'd6);
      send_bit(1'b1); send_bit(1'b0);
      for (int i = 15; i >= 1; i--) send_bit(logic'((16'h6789 >> i) & 1));
      repeat (2*HALF) @(negedge clk);
      chk(ctl2_o, 16'h0000, "R11", "ctl2 before final bit");
      send_bit(1'b1);
      repeat (2*HALF) @(negedge clk);
      chk(ctl2_o, 16'h6789, "R11", "ctl2 after final bit");
      s_c2 = 16'h6789;

      // R1 foreign addresses
      do_write(32, 2'b01, 5'h00, 5'd5, 16'hFFFF);
      chk(ctl1_o, s_c1, "R1", "write to addr 0 ignored");
      chk(saw_oe, 1'b0, "R1", "no drive on addr 0 write");
      do_write(32, 2'b01, 5'h1B, 5'd5, 16'h0001);
      chk(ctl1_o, s_c1, "R1", "write to addr 0x1B ignored");
      do_read(5'h00, 5'd2, v, tr, t2);
      chk(tr, 19'h0, "R1", "no drive on addr 0 read");
      chk(saw_oe, 1'b0, "R1", "no drive in addr 0 header");
      do_read(5'h0A, 5'd5, v, tr, t2);
      chk(tr, 19'h0, "R1", "no drive on addr 0x0A read");

      // R9 short preamble and bad opcodes
      do_write(32, 2'b01, 5'h1A, 5'd5, 16'h1234);
      do_write(31, 2'b01, 5'h1A, 5'd5, 16'h0F0F);
      chk(ctl1_o, s_c1, "R9", "31-one preamble ignored");
      chk(saw_oe, 1'b0, "R9", "no drive after short preamble");
      do_write(32, 2'b00, 5'h1A, 5'd5, 16'h0F0F);
      chk(ctl1_o, s_c1, "R9", "opcode 00 ignored");
      chk(saw_oe, 1'b0, "R9", "no drive opcode 00");
      do_write(32, 2'b11, 5'h1A, 5'd5, 16'h0F0F);
      chk(ctl1_o, s_c1, "R9", "opcode 11 ignored");
      chk(saw_oe, 1'b0, "R9", "no drive opcode 11");
      do_write(32, 2'b01, 5'h1A, 5'd5, 16'h0F0F); s_c1 = 16'h0F0F;
      chk(ctl1_o, 16'h0F0F, "R9", "valid frame after rejects");

      // full write sweep then full read sweep (R8 and all others)
      status_in = 16'h3C96;
      for (int a = 0; a < 32; a++) begin
         logic [4:0]  ra = 5'(a);
         logic [15:0] d  = {ra[3:0], ~ra[3:0], ra[3:0] ^ 4'hA, 3'h3, ra[4]};
         do_write(32, 2'b01, 5'h1A, ra, d);
         if (ra == 5'd4) s_id3 = d;
         if (ra == 5'd5) s_c1 = d;
         if (ra == 5'd6) s_c2 = d;
         if (ra == 5'd7) s_c3 = d;
         if (ra == 5'd12) s_wdt = d[7:0];
      end
      chk(ctl1_o, s_c1, "R8", "ctl1 after sweep");
      chk(ctl2_o, s_c2, "R8", "ctl2 after sweep");
      chk(ctl3_o, s_c3, "R8", "ctl3 after sweep");
      chk(ident3_o, s_id3, "R8", "ident3 after sweep");
      chk(wdt_time_o, s_wdt, "R7", "wdt after sweep");
      for (int a = 0; a < 32; a++) begin
         do_read(5'h1A, 5'(a), v, tr, t2);
         chk(v, exp_rd(5'(a)), req_of(5'(a)), $sformatf("sweep read reg %0d", a));
         chk(tr, TR_HIT, "R10", $sformatf("sweep trace reg %0d", a));
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule